// File: doc/BRIEF.md
# Two-Bit Serial Frame Sender with Parity

This block turns a two-bit message into a short framed serial burst on one output line, one bit per clock. It rests in an idle state with the line high and the ready flag raised. A one-cycle enable pulse in that state loads the message into the block. The block then sends a low start bit. Next come the message bits, lowest bit first. Last comes a parity bit that makes the total count of ones in data plus parity odd. After that the block drops back to idle.

The ready flag tells a producer when a new message can be handed over. Both outputs come from flip-flops, so the line never glitches when the message or enable inputs change. Once a frame has started, the enable input has no effect. A new frame can start only from idle, so back-to-back frames always have at least one high idle bit between them.

Top module: `ser_frame_tx`

## Requirements
- R1: Synchronous active-high reset sets ready_o = 1 and txd_o = 1 at the next rising edge, from any state, including in the middle of a frame.
- R2: In idle, each rising edge with en_i = 0 keeps ready_o = 1 and txd_o = 1.
- R3: A rising edge with en_i = 1 while ready_o = 1 starts a frame. After that edge ready_o = 0 and txd_o = 0, which is the start bit.
- R4: In the next two cycles txd_o carries message bit 0 and then message bit 1, while ready_o stays 0.
- R5: The message is taken from msg_i at the starting edge. Later changes of msg_i do not alter any bit of the frame.
- R6: In the fourth cycle of the frame, txd_o is the parity bit: 1 when the message holds an even number of ones (0 or 2), otherwise 0. ready_o is still 0.
- R7: After the parity cycle the block is idle again with ready_o = 1 and txd_o = 1. ready_o is low for exactly four cycles per frame.
- R8: en_i is ignored while ready_o = 0. If en_i is held at 1 throughout, the next frame begins exactly one idle cycle after the previous one ends.
- R9: ready_o and txd_o change only at rising clock edges. Changes of msg_i or en_i between edges do not reach them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| msg_i | input | 2 | Message to send; bit 0 goes out first |
| en_i | input | 1 | Start strobe, acted on only in idle |
| ready_o | output | 1 | High while idle and able to accept a message |
| txd_o | output | 1 | Serial line: idle high, start, data, parity |

## Verification
Every one of the four message values is sent. Each gives a different pair of data bits and two parity results, so a swapped bit order or an inverted parity sense shows up. One frame has its message inverted right after the start edge, which separates a captured message from a live one. Holding the enable high across frames shows whether the enable is ignored in mid-frame and whether the one-cycle gap holds. A reset in the middle of a frame and an enable pulse between clock edges test the reset path and the registered outputs.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_DATA   = 2'd2,
    ST_PARITY = 2'd3
  } sft_state_e;

  // Parity bit that makes data plus parity hold an odd number of ones.
  function automatic logic odd_fill(input logic [1:0] m);
    return ~(m[0] ^ m[1]);
  endfunction

  // Line level for a given next state.
  function automatic logic line_level(input sft_state_e st, input logic data_bit,
                                      input logic par_bit);
    case (st)
      ST_IDLE:   return 1'b1;
      ST_START:  return 1'b0;
      ST_DATA:   return data_bit;
      default:   return par_bit;
    endcase
  endfunction

endpackage

// File: rtl/sft_seq.sv
module sft_seq
  import sft_pkg::*;
#(
  parameter int MSG_W = 2,
  localparam int IDX_W = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output sft_state_e       nxt_state_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             launch_o
);

  sft_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_W - 1);

  always_comb begin
    nxt_state_o = state_q;
    nxt_idx_o   = idx_q;
    launch_o    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          nxt_state_o = ST_START;
          launch_o    = 1'b1;
        end
      end
      ST_START: begin
        nxt_state_o = ST_DATA;
        nxt_idx_o   = '0;
      end
      ST_DATA: begin
        if (idx_q == LAST_IDX) nxt_state_o = ST_PARITY;
        else                   nxt_idx_o   = idx_q + 1'b1;
      end
      default: nxt_state_o = ST_IDLE;
    endcase
    if (rst) begin
      nxt_state_o = ST_IDLE;
      nxt_idx_o   = '0;
      launch_o    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= nxt_state_o;
    idx_q   <= nxt_idx_o;
  end

endmodule

// File: rtl/sft_msg_hold.sv
module sft_msg_hold #(
  parameter int MSG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic [MSG_W-1:0] held_o
);

  always_ff @(posedge clk) begin
    if (rst)         held_o <= '0;
    else if (load_i) held_o <= msg_i;
  end

endmodule

// File: rtl/sft_line_out.sv
module sft_line_out
  import sft_pkg::*;
#(
  parameter int MSG_W = 2,
  localparam int IDX_W = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic             clk,
  input  sft_state_e       nxt_state_i,
  input  logic [IDX_W-1:0] nxt_idx_i,
  input  logic [MSG_W-1:0] held_i,
  output logic             ready_o,
  output logic             txd_o
);

  logic data_bit, par_bit;

  always_comb begin
    data_bit = held_i[nxt_idx_i];
    par_bit  = odd_fill(held_i);
  end

  always_ff @(posedge clk) begin
    ready_o <= (nxt_state_i == ST_IDLE);
    txd_o   <= line_level(nxt_state_i, data_bit, par_bit);
  end

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import sft_pkg::*;
#(
  parameter int MSG_W = 2,
  localparam int IDX_W = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MSG_W-1:0] msg_i,
  input  logic             en_i,
  output logic             ready_o,
  output logic             txd_o
);

  sft_state_e       nxt_state_w;
  logic [IDX_W-1:0] nxt_idx_w;
  logic             launch_w;
  logic [MSG_W-1:0] held_w;

  sft_seq #(.MSG_W(MSG_W)) seq_i (
    .clk(clk), .rst(rst), .en_i(en_i),
    .nxt_state_o(nxt_state_w), .nxt_idx_o(nxt_idx_w), .launch_o(launch_w)
  );

  sft_msg_hold #(.MSG_W(MSG_W)) hold_i (
    .clk(clk), .rst(rst), .load_i(launch_w), .msg_i(msg_i), .held_o(held_w)
  );

  sft_line_out #(.MSG_W(MSG_W)) out_i (
    .clk(clk), .nxt_state_i(nxt_state_w), .nxt_idx_i(nxt_idx_w),
    .held_i(held_w), .ready_o(ready_o), .txd_o(txd_o)
  );

endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk #(
  parameter int MSG_W = 2,
  localparam int FRAME = MSG_W + 2,
  localparam int POS_W = $clog2(FRAME + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [MSG_W-1:0] msg_i,
  input logic             en_i,
  input logic             ready_o,
  input logic             txd_o,
  input logic             start_evt
);

  logic [POS_W-1:0] pos_q;
  logic [MSG_W-1:0] snap_q;
  logic             exp_data;
  logic             in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      snap_q <= '0;
    end else if (pos_q == '0 && en_i) begin
      pos_q  <= POS_W'(1);
      snap_q <= msg_i;
    end else if (pos_q != '0) begin
      pos_q <= (pos_q == POS_W'(FRAME)) ? '0 : pos_q + 1'b1;
    end
  end

  always_comb begin
    in_data  = (pos_q >= POS_W'(2)) && (pos_q <= POS_W'(MSG_W + 1));
    exp_data = 1'b0;
    for (int i = 0; i < MSG_W; i++)
      if (int'(pos_q) == i + 2) exp_data = snap_q[i];
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready_o && txd_o));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !en_i) |=> (ready_o && txd_o));

  assert_launch_start_R3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && en_i) |=> (!ready_o && !txd_o));

  assert_launch_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> ready_o);

  assert_data_bits_R4: assert property (@(posedge clk) disable iff (rst)
    in_data |-> (!ready_o && txd_o == exp_data));

  assert_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (pos_q == POS_W'(FRAME)) |-> (!ready_o && txd_o == (($countones(snap_q) % 2) == 0)));

  assert_ready_window_R7: assert property (@(posedge clk) disable iff (rst)
    (pos_q == '0) |-> (ready_o && txd_o));

endmodule

bind ser_frame_tx ser_frame_tx_chk #(.MSG_W(MSG_W)) chk_i (
  .clk(clk), .rst(rst), .msg_i(msg_i), .en_i(en_i),
  .ready_o(ready_o), .txd_o(txd_o), .start_evt(launch_w)
);

// File: tb/ser_frame_tx_tb.sv
module ser_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] msg = 2'b00;
  logic       en  = 1'b0;
  logic       ready, txd;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  ser_frame_tx dut_i (
    .clk(clk), .rst(rst), .msg_i(msg), .en_i(en),
    .ready_o(ready), .txd_o(txd)
  );

  task automatic chk(input string req, input logic exp_r, input logic exp_y);
    n_chk++;
    if (ready !== exp_r || txd !== exp_y) begin
      n_fail++;
      $display("FAIL %s: ready=%b txd=%b expected ready=%b txd=%b",
               req, ready, txd, exp_r, exp_y);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Bench parity: 1 when the count of ones is 0 or 2.
  function automatic logic ref_par(input logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < 2; i++) if (m[i]) ones++;
    return (ones == 1) ? 1'b0 : 1'b1;
  endfunction

  // Starts a frame and checks its five output cycles.
  // scramble: invert msg after the start edge (R5); hold_en: keep en high (R8).
  task automatic send_frame(input logic [1:0] m, input bit scramble, input bit hold_en);
    @(negedge clk); msg = m; en = 1'b1;
    tick(); chk("R3 start bit", 1'b0, 1'b0);
    @(negedge clk); if (scramble) msg = ~m; en = hold_en;
    tick(); chk("R4 data bit0", 1'b0, m[0]);
    tick(); chk("R4 data bit1", 1'b0, m[1]);
    if (scramble) chk("R5 captured msg", 1'b0, m[1]);
    tick(); chk("R6 parity", 1'b0, ref_par(m));
    tick(); chk("R7 back to idle", 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0;
    tick(); tick();
    chk("R1 reset state", 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_idle_hold();
    @(negedge clk); en = 1'b0; msg = 2'b01;
    for (int i = 0; i < 4; i++) begin
      tick(); chk("R2 idle hold", 1'b1, 1'b1);
    end
  endtask

  task automatic t_all_messages();
    for (int v = 0; v < 4; v++) begin
      send_frame(2'(v), 1'b0, 1'b0);
      tick(); chk("R2 idle after frame", 1'b1, 1'b1);
    end
  endtask

  task automatic t_scramble();
    send_frame(2'b01, 1'b1, 1'b0);
    send_frame(2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back();
    send_frame(2'b11, 1'b0, 1'b1);
    // en still high: start is accepted at the next edge, one idle cycle gap
    tick(); chk("R8 next start after one idle", 1'b0, 1'b0);
    @(negedge clk); msg = 2'b10; en = 1'b0;
    tick(); chk("R8 second frame bit0", 1'b0, 1'b1);
    tick(); chk("R8 second frame bit1", 1'b0, 1'b1);
    tick(); chk("R8 second frame parity", 1'b0, 1'b1);
    tick(); chk("R7 second frame ends", 1'b1, 1'b1);
  endtask

  task automatic t_registered();
    @(negedge clk); en = 1'b1; msg = 2'b00;
    #1 chk("R9 no combinational path", 1'b1, 1'b1);
    en = 1'b0;
    tick(); chk("R9 short pulse between edges ignored", 1'b1, 1'b1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); msg = 2'b01; en = 1'b1;
    tick(); chk("R3 start before reset", 1'b0, 1'b0);
    @(negedge clk); en = 1'b0;
    tick(); chk("R4 bit0 before reset", 1'b0, 1'b1);
    @(negedge clk); rst = 1'b1;
    tick(); chk("R1 reset mid frame", 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0;
    tick(); chk("R1 idle after reset", 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_all_messages();
    t_scramble();
    t_back_to_back();
    t_registered();
    t_reset_mid();
    send_frame(2'b10, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule